// File: doc/BRIEF.md
# Opcode-Snooping I/O Trigger

This block watches the data bus of an 8-bit processor while it fetches opcodes. The processor's instruction set has a group of unused opcodes that run as one-cycle no-operations. Any opcode whose three low bits are binary 011 belongs to that group. When the block sees one of these opcodes during a valid fetch, it captures the other five opcode bits as a command. It then turns that command into a write to an 8-entry addressable latch.

Software performs an output action by placing one of these opcodes in its instruction stream. The action takes no address range and needs no processor register to be saved or loaded. Every piece of the command comes from the opcode byte. A bus cycle counts as a fetch only when the sync strobe and the valid-cycle qualifier are both high. Operand and data bytes that match the pattern therefore never cause a trigger.

Top module: `opcode_io_trigger`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `trig`, `latch_wr`, `payload`, `latch_sel`, `latch_bit`, `aux_flag` and all eight `latch_q` bits are 0.
- R2: A qualifying fetch is a rising clock edge at which `fetch_sync`=1, `cycle_valid`=1 and `bus_data[2:0]`=3'b011. Such a fetch makes `trig` and `latch_wr` high for the one clock cycle that follows that edge.
- R3: An edge with `fetch_sync`=0, with `cycle_valid`=0, or with `bus_data[2:0]` other than 3'b011 leaves `trig` and `latch_wr` low in the following cycle. It also leaves `latch_q`, `payload`, `latch_sel`, `latch_bit` and `aux_flag` unchanged.
- R4: After a qualifying fetch, `payload` equals `bus_data[7:3]` from that fetch. It holds this value until the next qualifying fetch.
- R5: After a qualifying fetch, `latch_sel` equals `bus_data[7:5]` and `latch_bit` equals `bus_data[4]`. In the same cycle that `trig` is high, `latch_q[latch_sel]` takes the value of `latch_bit`, and the other seven latch bits keep their values.
- R6: After a qualifying fetch, `aux_flag` holds `bus_data[3]` from that fetch until the next qualifying fetch.
- R7: When qualifying fetches come on consecutive edges, `trig` stays high for each of the following cycles, one cycle per fetch. Each fetch's latch write is applied in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_sync | input | 1 | High during an opcode fetch cycle |
| cycle_valid | input | 1 | High when the current bus cycle is valid |
| bus_data | input | 8 | Processor data bus |
| trig | output | 1 | One-cycle pulse per qualifying fetch |
| payload | output | 5 | Captured spare opcode bits [7:3] |
| latch_sel | output | 3 | Latch entry selected by the last command |
| latch_bit | output | 1 | Data bit of the last command |
| latch_wr | output | 1 | Latch write strobe, one cycle |
| aux_flag | output | 1 | Opcode bit 3 of the last command |
| latch_q | output | 8 | Addressable latch outputs |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 3-bit tag with value 011, and a 3-bit select, which gives eight latch entries. With these values every latch entry and every level of the data bit can be reached through random opcodes. The random stimulus is biased so that about half of the fetches match the tag. The bench also clears the sync and valid qualifiers at random, which exercises the rejection cases. Directed runs cover back-to-back trigger opcodes, the same entry written twice in a row, and opcodes that match the pattern but arrive with only one qualifier high.

// File: rtl/opcode_io_trigger.sv
module opcode_io_trigger #(
  parameter int DATA_W = 8,
  parameter int TAG_W = 3,
  parameter logic [TAG_W-1:0] TAG_VAL = 3'b011,
  parameter int SEL_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_sync,
  input  logic cycle_valid,
  input  logic [DATA_W-1:0] bus_data,
  output logic trig,
  output logic [DATA_W-TAG_W-1:0] payload,
  output logic [SEL_W-1:0] latch_sel,
  output logic latch_bit,
  output logic latch_wr,
  output logic aux_flag,
  output logic [(1<<SEL_W)-1:0] latch_q
);
  localparam int PAY_W = DATA_W - TAG_W;
  localparam int BIT_POS = DATA_W - SEL_W - 1;
  localparam int FLAG_POS = DATA_W - SEL_W - 2;

  logic hit;
  logic [SEL_W-1:0] sel_d;
  logic bit_d;

  assign hit   = fetch_sync && cycle_valid && (bus_data[TAG_W-1:0] == TAG_VAL);
  assign sel_d = bus_data[DATA_W-1 -: SEL_W];
  assign bit_d = bus_data[BIT_POS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig      <= 1'b0;
      latch_wr  <= 1'b0;
      payload   <= '0;
      latch_sel <= '0;
      latch_bit <= 1'b0;
      aux_flag  <= 1'b0;
      latch_q   <= '0;
    end else begin
      trig     <= hit;
      latch_wr <= hit;
      if (hit) begin
        payload        <= bus_data[DATA_W-1 -: PAY_W];
        latch_sel      <= sel_d;
        latch_bit      <= bit_d;
        aux_flag       <= bus_data[FLAG_POS];
        latch_q[sel_d] <= bit_d;
      end
    end
  end
endmodule

module opcode_io_trigger_chk #(
  parameter int DATA_W = 8,
  parameter int TAG_W = 3,
  parameter logic [TAG_W-1:0] TAG_VAL = 3'b011,
  parameter int SEL_W = 3
) (
  input logic clk,
  input logic rst_n,
  input logic fetch_sync,
  input logic cycle_valid,
  input logic [DATA_W-1:0] bus_data,
  input logic trig,
  input logic [DATA_W-TAG_W-1:0] payload,
  input logic [SEL_W-1:0] latch_sel,
  input logic latch_bit,
  input logic latch_wr,
  input logic aux_flag,
  input logic [(1<<SEL_W)-1:0] latch_q
);
  logic q;
  assign q = fetch_sync && cycle_valid && (bus_data[TAG_W-1:0] == TAG_VAL);

  p_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q |=> (trig && latch_wr));
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !q |=> (!trig && !latch_wr));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !q |=> ($stable(latch_q) && $stable(payload) && $stable(aux_flag)));
  p_payload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q |=> (payload == $past(bus_data[DATA_W-1 -: DATA_W-TAG_W])));
  p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (latch_q[latch_sel] == latch_bit));
  p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q |=> (aux_flag == $past(bus_data[DATA_W-SEL_W-2])));
  p_onebit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(latch_q ^ $past(latch_q)) <= 1));
endmodule

bind opcode_io_trigger opcode_io_trigger_chk #(
  .DATA_W(DATA_W), .TAG_W(TAG_W), .TAG_VAL(TAG_VAL), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_sync(fetch_sync), .cycle_valid(cycle_valid),
  .bus_data(bus_data), .trig(trig), .payload(payload), .latch_sel(latch_sel),
  .latch_bit(latch_bit), .latch_wr(latch_wr), .aux_flag(aux_flag), .latch_q(latch_q)
);

// File: tb/test_opcode_io_trigger.sv
`timescale 1ns/1ps
module test_opcode_io_trigger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_sync = 1'b0, cycle_valid = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic trig, latch_bit, latch_wr, aux_flag;
  logic [4:0] payload;
  logic [2:0] latch_sel;
  logic [7:0] latch_q;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic e_trig = 0, e_bit = 0, e_flag = 0;
  logic [4:0] e_pay = 0;
  logic [2:0] e_sel = 0;
  logic [7:0] e_latch = 0;

  always #2.5 clk = ~clk;

  opcode_io_trigger i_opcode_io_trigger (
    .clk(clk), .rst_n(rst_n), .fetch_sync(fetch_sync), .cycle_valid(cycle_valid),
    .bus_data(bus_data), .trig(trig), .payload(payload), .latch_sel(latch_sel),
    .latch_bit(latch_bit), .latch_wr(latch_wr), .aux_flag(aux_flag), .latch_q(latch_q)
  );

  function automatic logic qualifies(logic s, logic v, logic [7:0] d);
    return s && v && (d[2:0] == 3'b011);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string ttag);
    string lt;
    lt = e_trig ? "R5" : "R3";
    chk(ttag, "trig", trig, e_trig);
    chk(ttag, "latch_wr", latch_wr, e_trig);
    chk("R4", "payload", payload, e_pay);
    chk("R5", "latch_sel", latch_sel, e_sel);
    chk("R5", "latch_bit", latch_bit, e_bit);
    chk("R6", "aux_flag", aux_flag, e_flag);
    chk(lt, "latch_q", latch_q, e_latch);
  endtask

  task automatic step(logic s, logic v, logic [7:0] d, string ttag = "");
    logic q;
    @(negedge clk);
    fetch_sync = s; cycle_valid = v; bus_data = d;
    @(posedge clk);
    q = qualifies(s, v, d);
    e_trig = q;
    if (q) begin
      e_pay = d[7:3]; e_sel = d[7:5]; e_bit = d[4]; e_flag = d[3];
      e_latch[d[7:5]] = d[4];
    end
    #1;
    check_all(ttag != "" ? ttag : (q ? "R2" : "R3"));
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    fetch_sync = 1; cycle_valid = 1; bus_data = 8'hFB;
    repeat (3) @(posedge clk);
    #1 check_all("R1");
    @(negedge clk); rst_n = 1; fetch_sync = 0; cycle_valid = 0;
    @(posedge clk); #1 check_all("R1");

    step(1, 1, 8'b1011_1011);
    step(0, 0, 8'h00);
    step(0, 1, 8'b0111_0011, "R3");
    step(1, 0, 8'b0101_0011, "R3");
    step(1, 1, 8'b0101_0010, "R3");
    step(1, 1, 8'b0011_0011, "R7");
    step(1, 1, 8'b0101_1011, "R7");
    step(1, 1, 8'b0100_0011, "R7");
    step(1, 1, 8'b1111_1011, "R7");
    step(0, 0, 8'h00);
    for (int i = 0; i < 8; i++) step(1, 1, {i[2:0], 1'b1, 1'b0, 3'b011});
    for (int i = 0; i < 8; i++) step(1, 1, {i[2:0], 1'b0, 1'b1, 3'b011});

    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      logic s, v;
      d = 8'($urandom);
      if ($urandom % 2 == 0) d[2:0] = 3'b011;
      s = ($urandom % 4) != 0;
      v = ($urandom % 4) != 0;
      step(s, v, d);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule